// File: doc/BRIEF.md
# I2C Start and Stop Condition Timer

This block places I2C START and STOP conditions on an open-drain bus. It drives two pull-low enables, one for SCL and one for SDA, and spaces the edges from a single even count held in a control register. A one-cycle request pulse starts a condition. A one-cycle `done` pulse reports that the condition and its hold interval are complete. The byte engine that sits beside it is expected to issue a START, shift its bytes, and then issue a STOP.

The block runs on a clock at twice the system rate, so one clock tick is half a system cycle. With count N, the SDA setup interval and the SDA hold interval each last N+1 ticks, which is (N+1)/2 system cycles. SCL stays released for the sum of the two, which is N+1 system cycles. The same register also selects which bus line feeds an edge interrupt and which edge of that line is reported. The interrupt comes from synchronised copies of the bus line levels.

Top module: `i2c_cond_timer`

## Requirements
- R1: The control register reads back on `rd_data` as follows: bits 4:0 hold the count N, bit 5 selects the interrupt edge (0 falling, 1 rising), and bit 6 selects the interrupt line (0 SDA, 1 SCL). A write with `wr_en` high takes effect at that clock edge. The register resets to 0x00.
- R2: When an odd count is written, bit 0 is cleared and the stored count becomes the even value below it (a written 7 reads back as 6).
- R3: Bit 7 is reserved. Writing 1 to it has no effect, and it always reads back as 0.
- R4: All timing is counted in clock ticks of half a system cycle each. Setup and hold are each N+1 ticks, and SCL is released for 2(N+1) ticks in total.
- R5: START: `start_req` is sampled at edge E0. SDA is pulled low (`sda_oe` rises) at edge E0+N+1 while SCL stays released. SCL is pulled low (`scl_oe` rises) at edge E0+2N+2.
- R6: STOP: at edge E0, SCL is released and SDA is pulled low. SDA is released at edge E0+N+1. The condition completes at edge E0+2N+2 with SCL still released.
- R7: `done` goes high for exactly one cycle, at the edge that ends the hold interval (E0+2N+2).
- R8: The count is captured when the request is accepted. A register write during a condition does not change that condition's timing.
- R9: A request that arrives while a condition is in progress is ignored. If `start_req` and `stop_req` arrive together while idle, a START is performed.
- R10: The selected line is passed through two synchroniser stages. When it makes the selected transition just after edge c, `irq` is high for exactly the one cycle that follows edge c+3. Transitions in the other direction, and transitions on the other line, give no pulse.
- R11: Reset is synchronous and active high. During reset, `scl_oe`, `sda_oe`, `done` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| start_req | input | 1 | One-cycle START request |
| stop_req | input | 1 | One-cycle STOP request |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle bus-line edge pulse |

## Verification
For each request, the driver computes due cycles from the accepting edge E0: the SDA edge is due N+1 edges later, and the final SCL edge together with `done` is due 2N+2 edges later. An interrupt is due three edges after the bus line moves, and the bench models the bus line as the inverse of the block's own pull-low enable. These expected events go into a queue sorted by cycle. Once per cycle the monitor samples the outputs at the falling clock edge and turns every output change, and every cycle in which a pulse is high, into an observed event. It matches each observed event against the head of the queue for both kind and cycle number, so an early, late, missing or extra edge each fails a check. Register readback is compared in the cycle after each write.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int CNT_W  = 5;
    localparam int CTRL_W = CNT_W + 3;

    typedef struct packed {
        logic             rsvd;
        logic             line_scl;
        logic             edge_rise;
        logic [CNT_W-1:0] count;
    } cond_ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HOLD
    } cond_phase_e;

    typedef enum logic {
        OP_START,
        OP_STOP
    } cond_op_e;

    function automatic cond_ctrl_t clean_ctrl(input logic [CTRL_W-1:0] raw);
        cond_ctrl_t c;
        c          = cond_ctrl_t'(raw);
        c.rsvd     = 1'b0;
        c.count[0] = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/i2c_cond_ctrl_reg.sv
module i2c_cond_ctrl_reg
    import i2c_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output cond_ctrl_t        ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= clean_ctrl(wr_data);
        end
    end

endmodule

// File: rtl/i2c_cond_sequencer.sv
module i2c_cond_sequencer
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] count,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done
);

    cond_phase_e      phase;
    cond_op_e         op;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            op     <= OP_START;
            remain <= '0;
            snap   <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_req) begin
                        op     <= OP_START;
                        phase  <= PH_SETUP;
                        remain <= count;
                        snap   <= count;
                    end else if (stop_req) begin
                        op     <= OP_STOP;
                        phase  <= PH_SETUP;
                        remain <= count;
                        snap   <= count;
                        scl_oe <= 1'b0;
                        sda_oe <= 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (remain == '0) begin
                        phase  <= PH_HOLD;
                        remain <= snap;
                        sda_oe <= (op == OP_START);
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (remain == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        if (op == OP_START) begin
                            scl_oe <= 1'b1;
                        end
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_line_edge_irq.sv
module i2c_line_edge_irq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic line_scl,
    input  logic edge_rise,
    output logic irq
);

    localparam int LINES = 2;
    localparam int HIST  = SYNC_STAGES + 1;

    logic [LINES-1:0] raw;
    logic [HIST-1:0]  chain [LINES];
    logic [LINES-1:0] now_lvl;
    logic [LINES-1:0] old_lvl;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= '1;
            end else begin
                chain[g] <= {chain[g][HIST-2:0], raw[g]};
            end
        end
        assign now_lvl[g] = chain[g][SYNC_STAGES-1];
        assign old_lvl[g] = chain[g][SYNC_STAGES];
    end

    logic sel_now;
    logic sel_old;
    logic hit;

    always_comb begin
        sel_now = line_scl ? now_lvl[1] : now_lvl[0];
        sel_old = line_scl ? old_lvl[1] : old_lvl[0];
        hit     = edge_rise ? (sel_now & ~sel_old) : (~sel_now & sel_old);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= hit;
        end
    end

endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer
    import i2c_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              done,
    output logic              irq
);

    cond_ctrl_t ctrl;

    i2c_cond_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign rd_data = ctrl;

    i2c_cond_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .count     (ctrl.count),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done)
    );

    i2c_line_edge_irq #(.SYNC_STAGES(2)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .line_scl  (ctrl.line_scl),
        .edge_rise (ctrl.edge_rise),
        .irq       (irq)
    );

endmodule

// File: rtl/i2c_cond_timer_chk.sv
module i2c_cond_timer_chk
    import i2c_cond_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              done,
    input logic              irq
);

    a_r1_write_fields: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[CTRL_W-2:1] == $past(wr_data[CTRL_W-2:1]));

    // R2 and R3: bit 0 and bit 7 never hold a 1 after any write
    a_r3_rsvd_and_even: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[CTRL_W-1] == 1'b0 && rd_data[0] == 1'b0));

    a_r5_scl_low_ends: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> done);

    a_r5_sda_moves_scl_high: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_oe);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!scl_oe && !sda_oe && !done && !irq));

endmodule

bind i2c_cond_timer i2c_cond_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .done    (done),
    .irq     (irq)
);

// File: tb/i2c_cond_timer_test.sv
`timescale 1ns/1ps
module i2c_cond_timer_test;

    localparam int K_SCL_REL = 0;
    localparam int K_SCL_LOW = 1;
    localparam int K_SDA_REL = 2;
    localparam int K_SDA_LOW = 3;
    localparam int K_DONE    = 4;
    localparam int K_IRQ     = 5;

    typedef struct {
        int    kind;
        int    cyc;
        string tag;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       scl_oe, sda_oe, done, irq;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  mon_on = 0;
    bit  finished = 0;
    ev_t exp_q[$];

    int cfg_n = 0;
    bit cfg_rise = 0;
    bit cfg_scl = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_cond_timer uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .start_req (start_req),
        .stop_req  (stop_req),
        .scl_in    (~scl_oe),
        .sda_in    (~sda_oe),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done),
        .irq       (irq)
    );

    function automatic void push_ev(int kind, int at, string tag);
        ev_t e;
        int  pos;
        e.kind = kind;
        e.cyc  = at;
        e.tag  = tag;
        pos = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].cyc * 8 + exp_q[i].kind > at * 8 + kind) begin
                pos = i;
                break;
            end
        end
        exp_q.insert(pos, e);
    endfunction

    task automatic check_eq(int act, int expv, string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // monitor: turn output activity into events and pop the scoreboard
    logic p_scl = 0, p_sda = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            bit [5:0] seen;
            seen[K_SCL_REL] = p_scl && !scl_oe;
            seen[K_SCL_LOW] = !p_scl && scl_oe;
            seen[K_SDA_REL] = p_sda && !sda_oe;
            seen[K_SDA_LOW] = !p_sda && sda_oe;
            seen[K_DONE]    = done;
            seen[K_IRQ]     = irq;
            for (int k = 0; k < 6; k++) begin
                if (seen[k]) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL unexpected event: actual kind %0d at cycle %0d expected none", k, cyc);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        if (e.kind != k || e.cyc != cyc) begin
                            errors++;
                            $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                                     e.tag, k, cyc, e.kind, e.cyc);
                        end
                    end
                end
            end
            p_scl = scl_oe;
            p_sda = sda_oe;
        end
    end

    task automatic wr(logic [7:0] val, string tag);
        logic [7:0] expv;
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        expv = val & 8'h7E;
        check_eq(int'(rd_data), int'(expv), tag);
        cfg_n    = int'(expv[4:0]);
        cfg_rise = expv[5];
        cfg_scl  = expv[6];
    endtask

    task automatic push_start(int c0, string tag);
        push_ev(K_SDA_LOW, c0 + cfg_n + 1, tag);
        push_ev(K_SCL_LOW, c0 + 2 * cfg_n + 2, tag);
        push_ev(K_DONE, c0 + 2 * cfg_n + 2, "R7");
        if (!cfg_rise && !cfg_scl) push_ev(K_IRQ, c0 + cfg_n + 4, "R10");
        if (!cfg_rise && cfg_scl)  push_ev(K_IRQ, c0 + 2 * cfg_n + 5, "R10");
    endtask

    task automatic do_start(string tag);
        int c0;
        c0 = cyc + 1;
        start_req = 1'b1;
        push_start(c0, tag);
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic do_both();
        int c0;
        c0 = cyc + 1;
        start_req = 1'b1;
        stop_req  = 1'b1;
        push_start(c0, "R9");
        @(negedge clk);
        start_req = 1'b0;
        stop_req  = 1'b0;
    endtask

    task automatic do_stop(string tag);
        int c0;
        c0 = cyc + 1;
        stop_req = 1'b1;
        push_ev(K_SCL_REL, c0, tag);
        push_ev(K_SDA_REL, c0 + cfg_n + 1, tag);
        push_ev(K_DONE, c0 + 2 * cfg_n + 2, "R7");
        if (cfg_rise && cfg_scl)  push_ev(K_IRQ, c0 + 3, "R10");
        if (cfg_rise && !cfg_scl) push_ev(K_IRQ, c0 + cfg_n + 4, "R10");
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check_eq(int'(scl_oe), 0, "R11 scl_oe");
        check_eq(int'(sda_oe), 0, "R11 sda_oe");
        check_eq(int'(done), 0, "R11 done");
        check_eq(int'(irq), 0, "R11 irq");
        check_eq(int'(rd_data), 0, "R1 reset value");
        mon_on = 1;

        // R1, R4, R5, R6: count 4, SDA falling interrupt
        wr(8'h04, "R1");
        do_start("R5");
        settle(20);
        do_stop("R6");
        settle(20);

        // R2: odd count forced even
        wr(8'h07, "R2");
        do_start("R4");
        settle(25);
        do_stop("R4");
        settle(25);

        // R3: reserved bit ignored; SCL rising interrupt, count 26
        wr(8'hFA, "R3");
        do_start("R5");
        settle(70);
        do_stop("R6");
        settle(70);

        // R10: SCL falling interrupt, count 0
        wr(8'h40, "R10");
        do_start("R5");
        settle(10);
        do_stop("R6");
        settle(10);

        // R8 and R9: snapshot and ignored request during a START
        wr(8'h08, "R1");
        do_start("R8");
        settle(2);
        wr(8'h1E, "R8");
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        settle(30);
        do_stop("R6");
        settle(80);

        // R9: both requests together act as START
        wr(8'h02, "R1");
        do_both();
        settle(15);
        do_stop("R6");
        settle(15);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: actual %0d events missing expected 0", exp_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule